// File: doc/BRIEF.md
# Multi-Slot In-Order Commit with Precise Traps

This block sits at the retirement end of a multi-issue in-order pipeline. Each cycle it takes a group of up to four completed instructions, listed from oldest to youngest. Every instruction carries a valid flag, a fault flag, a fault cause code and its program counter. A fault is never acted on when it is raised. The block waits until the faulting instruction reaches this stage and then resolves it here, so that software always sees a precise machine state.

Within a group, every valid instruction older than the oldest faulting one retires. The faulting instruction is held back, and so is every instruction younger than it, including younger ones that arrive in the same group. When a fault is taken, the block issues a one-cycle flush request. It also loads the faulting instruction's PC into a trap-PC register and its cause code into a trap-cause register. Both registers keep their values until the next fault is taken. In the cycle the flush request is high, the incoming group is dropped, because it belongs to the path being discarded. Choosing the handler vector and refilling the pipeline are left to the surrounding logic.

Top module: `retire_gate`

## Requirements
- R1: While reset is held (rst_n low at a clock edge), all retire strobes, the flush request, the trap PC and the trap cause are cleared to zero.
- R2: All outputs are registered and appear one cycle after the group is sampled. When no valid slot in a group has its fault flag set, every valid slot's retire strobe is high.
- R3: A slot whose valid bit is low never retires. Its fault flag, cause and PC have no effect on any output.
- R4: Slot 0 is the oldest and slot 3 the youngest. Every valid slot with an index lower than the oldest valid faulting slot retires.
- R5: The oldest valid faulting slot does not retire, and no slot with a higher index retires in that group, even when it is valid and fault-free.
- R6: When several valid slots fault, the trap PC and trap cause are taken from the lowest-indexed one. Slot i occupies bits [i*W +: W] of the packed PC and cause inputs.
- R7: A group that contains a valid faulting slot raises the flush request for exactly one cycle, in the same cycle as that group's retire strobes.
- R8: The group sampled while the flush request is high is ignored: in the following cycle no slot retires and no flush is raised.
- R9: The trap PC and trap cause change only in a cycle where the flush request is high. Otherwise they hold their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| grp_valid | input | 4 | Per-slot valid, bit 0 is oldest |
| grp_fault | input | 4 | Per-slot fault flag |
| grp_cause | input | 20 | Per-slot 5-bit cause, slot i at [i*5 +: 5] |
| grp_pc | input | 128 | Per-slot 32-bit PC, slot i at [i*32 +: 32] |
| retire | output | 4 | Per-slot retire strobes |
| flush_req | output | 1 | One-cycle flush request |
| trap_pc | output | 32 | Trap PC register |
| trap_cause | output | 5 | Trap cause register |

## Verification
The bench builds the block with its defaults: four slots, 32-bit PCs and 5-bit causes. With four slots every fault position can be reached, including oldest, youngest and middle, as well as groups with two or more faults, where the lower-index priority is the only thing that decides the result. Random groups with a fault rate of roughly one in four make back-to-back faults common. This puts the dropped-group cycle of R8 under frequent pressure, together with invalid slots that carry stray fault flags.

// File: rtl/retire_pkg.sv
// Package retire_pkg
// Shared default widths for the retirement gate. All consumers take these
// as parameter defaults so that one place sets the configuration.
package retire_pkg;
    localparam int unsigned SLOTS_DFLT = 4;
    localparam int unsigned PC_W_DFLT  = 32;
    localparam int unsigned CAUSE_W_DFLT = 5;
endpackage

// File: rtl/retire_pick.sv
// Module retire_pick
// Combinational scan of a group in program order (slot 0 oldest).
// Produces the retire mask, a one-hot marker for the oldest valid faulting
// slot, and that slot's PC and cause. Assumes the caller has already
// cleared valid bits for groups that must be dropped.
module retire_pick #(
    parameter int unsigned SLOTS   = retire_pkg::SLOTS_DFLT,
    parameter int unsigned PC_W    = retire_pkg::PC_W_DFLT,
    parameter int unsigned CAUSE_W = retire_pkg::CAUSE_W_DFLT
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [SLOTS-1:0]           vld,
    input  logic [SLOTS-1:0]           flt,
    input  logic [SLOTS*CAUSE_W-1:0]   cause_bus,
    input  logic [SLOTS*PC_W-1:0]      pc_bus,
    output logic [SLOTS-1:0]           keep,
    output logic [SLOTS-1:0]           first_flt,
    output logic                       any_flt,
    output logic [PC_W-1:0]            sel_pc,
    output logic [CAUSE_W-1:0]         sel_cause
);
    logic [SLOTS:0]   older_flt;   // older_flt[i]: some slot below i faults
    logic [SLOTS-1:0] hit;

    assign older_flt[0] = 1'b0;

    genvar gi;
    generate
        for (gi = 0; gi < SLOTS; gi++) begin : g_scan
            // Per-slot: detect fault, propagate "older fault seen", gate retire
            assign hit[gi]           = vld[gi] & flt[gi];
            assign older_flt[gi + 1] = older_flt[gi] | hit[gi];
            assign keep[gi]          = vld[gi] & ~flt[gi] & ~older_flt[gi];
            assign first_flt[gi]     = hit[gi] & ~older_flt[gi];
        end
    endgenerate

    assign any_flt = older_flt[SLOTS];

    // AND-OR select of the winning slot's PC and cause
    always_comb begin
        sel_pc    = '0;
        sel_cause = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (first_flt[i]) begin
                sel_pc    = sel_pc    | pc_bus[i*PC_W +: PC_W];
                sel_cause = sel_cause | cause_bus[i*CAUSE_W +: CAUSE_W];
            end
        end
    end

    // R6: at most one slot may be chosen as the trap source
    a_r6_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(first_flt));
    // R5: a retiring slot and the winning fault never overlap
    a_r5_no_keep_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (keep & first_flt) == '0);
endmodule

// File: rtl/trap_latch.sv
// Module trap_latch
// Holds the trap PC and trap cause. Loads on a load strobe, otherwise
// holds. Synchronous active-low reset clears both to zero.
module trap_latch #(
    parameter int unsigned PC_W    = retire_pkg::PC_W_DFLT,
    parameter int unsigned CAUSE_W = retire_pkg::CAUSE_W_DFLT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [PC_W-1:0]    pc_in,
    input  logic [CAUSE_W-1:0] cause_in,
    input  logic               pulse_seen,
    output logic [PC_W-1:0]    pc_q,
    output logic [CAUSE_W-1:0] cause_q
);
    // Capture the trap PC/cause on a taken fault
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q    <= '0;
            cause_q <= '0;
        end else if (load) begin
            pc_q    <= pc_in;
            cause_q <= cause_in;
        end
    end

    // R9: registers change only alongside the flush pulse
    a_r9_hold_trap: assert property (@(posedge clk) disable iff (!rst_n)
        !pulse_seen |-> ($stable(pc_q) && $stable(cause_q)));
endmodule

// File: rtl/retire_gate.sv
// Module retire_gate (top)
// In-order multi-slot retirement with precise traps. Registers one cycle
// of latency from group to strobes. Assumes slots arrive in program order
// with slot 0 oldest; a group offered while flush_req is high is dropped.
module retire_gate #(
    parameter int unsigned SLOTS   = retire_pkg::SLOTS_DFLT,
    parameter int unsigned PC_W    = retire_pkg::PC_W_DFLT,
    parameter int unsigned CAUSE_W = retire_pkg::CAUSE_W_DFLT
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [SLOTS-1:0]         grp_valid,
    input  logic [SLOTS-1:0]         grp_fault,
    input  logic [SLOTS*CAUSE_W-1:0] grp_cause,
    input  logic [SLOTS*PC_W-1:0]    grp_pc,
    output logic [SLOTS-1:0]         retire,
    output logic                     flush_req,
    output logic [PC_W-1:0]          trap_pc,
    output logic [CAUSE_W-1:0]       trap_cause
);
    logic [SLOTS-1:0]   eff_valid;
    logic [SLOTS-1:0]   keep;
    logic [SLOTS-1:0]   first_flt;
    logic               any_flt;
    logic [PC_W-1:0]    sel_pc;
    logic [CAUSE_W-1:0] sel_cause;
    logic [SLOTS-1:0]   retire_q;
    logic               flush_q;

    // Drop the group that arrives during the flush cycle
    always_comb begin
        eff_valid = flush_q ? '0 : grp_valid;
    end

    retire_pick #(.SLOTS(SLOTS), .PC_W(PC_W), .CAUSE_W(CAUSE_W)) u_pick (
        .clk       (clk),
        .rst_n     (rst_n),
        .vld       (eff_valid),
        .flt       (grp_fault),
        .cause_bus (grp_cause),
        .pc_bus    (grp_pc),
        .keep      (keep),
        .first_flt (first_flt),
        .any_flt   (any_flt),
        .sel_pc    (sel_pc),
        .sel_cause (sel_cause)
    );

    trap_latch #(.PC_W(PC_W), .CAUSE_W(CAUSE_W)) u_trap (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (any_flt),
        .pc_in      (sel_pc),
        .cause_in   (sel_cause),
        .pulse_seen (flush_q),
        .pc_q       (trap_pc),
        .cause_q    (trap_cause)
    );

    // Register retire strobes and the flush request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            retire_q <= '0;
            flush_q  <= 1'b0;
        end else begin
            retire_q <= keep;
            flush_q  <= any_flt;
        end
    end

    assign retire    = retire_q;
    assign flush_req = flush_q;

    // R7: flush is a single-cycle pulse
    a_r7_flush_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |=> !flush_req);
    // R8: the group offered during flush produces no retirement
    a_r8_drop_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |=> (retire == '0));
    // R3: only slots that were valid may retire
    a_r3_valid_only: assert property (@(posedge clk) disable iff (!rst_n)
        (retire & ~$past(grp_valid)) == '0);
endmodule

// File: tb/retire_gate_tb_top.sv
// Bench for retire_gate: directed corners then seeded random groups,
// compared against a program-order reference model.
module retire_gate_tb_top;
    localparam int SLOTS = 4;
    localparam int PC_W = 32;
    localparam int CW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [SLOTS-1:0]      grp_valid = '0;
    logic [SLOTS-1:0]      grp_fault = '0;
    logic [SLOTS*CW-1:0]   grp_cause = '0;
    logic [SLOTS*PC_W-1:0] grp_pc = '0;
    logic [SLOTS-1:0]      retire;
    logic                  flush_req;
    logic [PC_W-1:0]       trap_pc;
    logic [CW-1:0]         trap_cause;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [SLOTS-1:0] x_ret;
    logic             x_flush;
    logic [PC_W-1:0]  x_pc;
    logic [CW-1:0]    x_cause;

    always #2.5 clk = ~clk;  // 200 MHz

    retire_gate dut_i (
        .clk(clk), .rst_n(rst_n),
        .grp_valid(grp_valid), .grp_fault(grp_fault),
        .grp_cause(grp_cause), .grp_pc(grp_pc),
        .retire(retire), .flush_req(flush_req),
        .trap_pc(trap_pc), .trap_cause(trap_cause)
    );

    task automatic check_all(input string tag);
        n_cmp++;
        if (retire !== x_ret) begin
            n_bad++;
            $display("FAIL %s R2 R3 R4 R5 retire act=%b exp=%b", tag, retire, x_ret);
        end
        n_cmp++;
        if (flush_req !== x_flush) begin
            n_bad++;
            $display("FAIL %s R7 R8 flush act=%b exp=%b", tag, flush_req, x_flush);
        end
        n_cmp++;
        if (trap_pc !== x_pc || trap_cause !== x_cause) begin
            n_bad++;
            $display("FAIL %s R6 R9 trap act=%h/%h exp=%h/%h", tag,
                     trap_pc, trap_cause, x_pc, x_cause);
        end
    endtask

    // Reference: apply one group, called at negedge; checks after next edge
    task automatic step(input logic [SLOTS-1:0] v, input logic [SLOTS-1:0] f,
                        input logic [SLOTS*CW-1:0] c, input logic [SLOTS*PC_W-1:0] p,
                        input string tag);
        logic blank;
        logic seen;
        blank = x_flush;
        grp_valid = v; grp_fault = f; grp_cause = c; grp_pc = p;
        x_ret = '0;
        x_flush = 1'b0;
        seen = 1'b0;
        if (!blank) begin
            for (int i = 0; i < SLOTS; i++) begin
                if (v[i] && !seen) begin
                    if (f[i]) begin
                        seen = 1'b1;
                        x_flush = 1'b1;
                        x_pc = p[i*PC_W +: PC_W];
                        x_cause = c[i*CW +: CW];
                    end else begin
                        x_ret[i] = 1'b1;
                    end
                end
            end
        end
        @(posedge clk);
        @(negedge clk);
        check_all(tag);
    endtask

    function automatic logic [SLOTS*PC_W-1:0] pcs(input int base);
        logic [SLOTS*PC_W-1:0] r;
        for (int i = 0; i < SLOTS; i++) r[i*PC_W +: PC_W] = 32'(base + 4*i);
        return r;
    endfunction

    localparam logic [SLOTS*CW-1:0] CZ = {5'd4, 5'd3, 5'd2, 5'd1};

    initial begin
        void'($urandom(32'd1773));
        x_ret = '0; x_flush = 1'b0; x_pc = '0; x_cause = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check_all("R1 reset");
        rst_n = 1'b1;
        // R2 no faults, all valid, then sparse valid
        step(4'b1111, 4'b0000, CZ, pcs(32'h100), "R2 all");
        step(4'b1010, 4'b0000, CZ, pcs(32'h200), "R2 sparse");
        // R3 invalid slot with fault flag is ignored
        step(4'b1101, 4'b0010, CZ, pcs(32'h300), "R3 stray");
        step(4'b0000, 4'b1111, CZ, pcs(32'h340), "R3 none");
        // R4 R5 fault in slot 2 cuts slot 3
        step(4'b1111, 4'b0100, CZ, pcs(32'h400), "R4 R5 mid");
        // R8 group during flush dropped
        step(4'b1111, 4'b0001, CZ, pcs(32'h500), "R8 drop");
        step(4'b1111, 4'b0000, CZ, pcs(32'h600), "R9 hold");
        // R6 two faults: slot 1 wins over slot 3
        step(4'b1111, 4'b1010, CZ, pcs(32'h700), "R6 prio");
        step(4'b0000, 4'b0000, CZ, pcs(32'h0), "R7 gap");
        // fault in oldest and in youngest slot
        step(4'b1111, 4'b0001, CZ, pcs(32'h800), "R5 oldest");
        step(4'b0000, 4'b0000, CZ, pcs(32'h0), "R7 gap2");
        step(4'b1111, 4'b1000, CZ, pcs(32'h900), "R4 youngest");
        // Random groups
        for (int k = 0; k < 3000; k++) begin
            logic [SLOTS-1:0] rv, rf;
            logic [SLOTS*CW-1:0] rc;
            logic [SLOTS*PC_W-1:0] rp;
            rv = SLOTS'($urandom);
            rf = '0;
            for (int i = 0; i < SLOTS; i++) rf[i] = (($urandom % 4) == 0);
            rc = SLOTS*CW'({$urandom, $urandom});
            rp = {$urandom, $urandom, $urandom, $urandom};
            step(rv, rf, rc, rp, "rand");
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_cmp++;
                n_bad++;
                $display("FAIL watchdog R1 act=timeout exp=done");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule